// File: doc/BRIEF.md
# PCM Voice Codec Framing Interface

This block connects the baseband core to an external PCM voice codec over a short serial link. From the system clock it derives a bit clock for the codec through an integer divider. It also produces a frame sync pulse, so that every frame spans 75 bit clocks. With a 600 kHz bit clock this gives an 8 kHz frame rate.

In each frame one 8-bit sample moves in each direction, most significant bit first, in the eight bit slots that follow the sync slot. The outgoing sample is taken from a parallel input at the start of the frame. The serial line toward the codec changes on rising bit-clock edges, so the codec can sample it on falling edges. The line from the codec is captured on falling edges, because the codec drives it on rising edges. Once the eighth incoming bit is in, a one-cycle strobe marks a new received byte on a parallel output.

Top module: `pcm_frame_if`

## Requirements
- R1: `bclk` has a period of `CLK_DIV` system clocks, with `CLK_DIV/2` cycles high and `CLK_DIV/2` cycles low (`CLK_DIV` even).
- R2: `fsync` rises once every `FRAME_SLOTS` bit clocks (75 by default), which is `FRAME_SLOTS*CLK_DIV` system clocks.
- R3: `fsync` is high for exactly one bit-clock period (slot 0, from one rising `bclk` edge to the next) and changes only together with a rising `bclk` edge.
- R4: In slots 1 to 8 after the sync slot, `dr` carries the outgoing byte, bit 7 first and bit 0 in slot 8. It changes only with a rising `bclk` edge, so it is stable at each falling edge.
- R5: `dr` is low in the sync slot and in the idle slots 9 to 74.
- R6: `dt` is sampled on the falling `bclk` edge of slots 1 to 8, with the slot 1 bit becoming bit 7 of `rx_sample`. Values on `dt` in other slots have no effect.
- R7: `rx_valid` is a single system-clock pulse, once per frame, raised with the falling `bclk` edge of slot 8. `rx_sample` changes only with that pulse and otherwise holds its value.
- R8: `tx_sample` is loaded only at the rising `bclk` edge that starts slot 0. A change later in the frame affects only the following frame.
- R9: While `rst_n` is low, `bclk`, `fsync`, `dr` and `rx_valid` are low and `rx_sample` is zero. After release, the first rising `bclk` edge comes `CLK_DIV/2` cycles later and opens a frame with `fsync` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_sample | input | SAMPLE_W | Outgoing voice sample, loaded at frame start |
| dt | input | 1 | Serial data from the codec |
| bclk | output | 1 | Codec bit clock |
| fsync | output | 1 | Frame sync, one bit period wide |
| dr | output | 1 | Serial data to the codec |
| rx_sample | output | SAMPLE_W | Last received voice sample |
| rx_valid | output | 1 | One-cycle strobe for a new rx_sample |

## Verification
The bench runs a table of frame pairs through the link, with a software codec model on the other end. Asymmetric bytes such as A5 and 3C show whether bits come out in the wrong order or off by one slot. All-zero, all-one and single-bit bytes (80, 01) show whether a bit lands exactly in the first or the last data slot. Some frames hold `dt` high through every idle slot, which shows whether capture is confined to slots 1 to 8. Other frames change `tx_sample` in mid-frame, which separates a load at the sync from a live path. A reset in mid-frame then checks that the link returns to idle and restarts with a sync.

// File: rtl/pcm_frame_if.sv
module pcm_frame_if #(
  parameter int CLK_DIV     = 40,
  parameter int FRAME_SLOTS = 75,
  parameter int SAMPLE_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] tx_sample,
  input  logic                dt,
  output logic                bclk,
  output logic                fsync,
  output logic                dr,
  output logic [SAMPLE_W-1:0] rx_sample,
  output logic                rx_valid
);
  localparam int HALF = CLK_DIV / 2;
  localparam int DW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int SW   = $clog2(FRAME_SLOTS);
  localparam int LAST = FRAME_SLOTS - 1;

  logic [DW-1:0]       div_cnt;
  logic [SW-1:0]       slot, slot_nxt;
  logic [SAMPLE_W-1:0] tx_sh;
  logic [SAMPLE_W-2:0] rx_sh;
  logic                rise_evt, fall_evt, tx_bit_nxt, rx_bit, rx_last;

  assign rise_evt   = div_cnt == DW'(HALF - 1);
  assign fall_evt   = div_cnt == DW'(CLK_DIV - 1);
  assign slot_nxt   = (slot == SW'(LAST)) ? '0 : slot + 1'b1;
  assign tx_bit_nxt = (slot_nxt != '0) && (slot_nxt <= SW'(SAMPLE_W));
  assign rx_bit     = (slot != '0) && (slot <= SW'(SAMPLE_W));
  assign rx_last    = slot == SW'(SAMPLE_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt <= '0;
      bclk    <= 1'b0;
    end else begin
      div_cnt <= fall_evt ? '0 : div_cnt + 1'b1;
      if (rise_evt)      bclk <= 1'b1;
      else if (fall_evt) bclk <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot  <= SW'(LAST);
      fsync <= 1'b0;
      dr    <= 1'b0;
      tx_sh <= '0;
    end else if (rise_evt) begin
      slot  <= slot_nxt;
      fsync <= slot_nxt == '0;
      dr    <= tx_bit_nxt ? tx_sh[SAMPLE_W-1] : 1'b0;
      if (slot_nxt == '0) tx_sh <= tx_sample;
      else if (tx_bit_nxt) tx_sh <= {tx_sh[SAMPLE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_sh     <= '0;
      rx_sample <= '0;
      rx_valid  <= 1'b0;
    end else begin
      rx_valid <= fall_evt && rx_last;
      if (fall_evt && rx_bit) rx_sh <= {rx_sh[SAMPLE_W-3:0], dt};
      if (fall_evt && rx_last) rx_sample <= {rx_sh, dt};
    end
  end
endmodule

module pcm_frame_if_chk #(
  parameter int CLK_DIV     = 40,
  parameter int FRAME_SLOTS = 75,
  parameter int SAMPLE_W    = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bclk,
  input logic                fsync,
  input logic                dr,
  input logic [SAMPLE_W-1:0] rx_sample,
  input logic                rx_valid
);
  localparam int HALF = CLK_DIV / 2;

  logic        bclk_d, fsync_d, ph_armed, fr_armed;
  logic [31:0] ph_cnt, fr_cnt;
  logic        tog, b_rise, f_rise;

  assign tog    = bclk != bclk_d;
  assign b_rise = bclk && !bclk_d;
  assign f_rise = fsync && !fsync_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_d   <= 1'b0;
      fsync_d  <= 1'b0;
      ph_armed <= 1'b0;
      fr_armed <= 1'b0;
      ph_cnt   <= '0;
      fr_cnt   <= '0;
    end else begin
      bclk_d  <= bclk;
      fsync_d <= fsync;
      if (tog) begin
        ph_cnt   <= '0;
        ph_armed <= 1'b1;
      end else begin
        ph_cnt <= ph_cnt + 1;
      end
      if (b_rise) begin
        if (f_rise) begin
          fr_cnt   <= 32'd1;
          fr_armed <= 1'b1;
        end else begin
          fr_cnt <= fr_cnt + 1;
        end
      end
    end
  end

  assert_bclk_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tog && ph_armed) |-> ph_cnt == 32'(HALF - 1));
  assert_frame_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (f_rise && fr_armed) |-> fr_cnt == 32'(FRAME_SLOTS));
  assert_fsync_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fsync) |-> $rose(bclk));
  assert_dr_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dr) |-> $rose(bclk));
  assert_sync_slot_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |-> !dr);
  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  assert_valid_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $fell(bclk));
  assert_sample_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_sample) |-> rx_valid);
endmodule

bind pcm_frame_if pcm_frame_if_chk #(
  .CLK_DIV(CLK_DIV), .FRAME_SLOTS(FRAME_SLOTS), .SAMPLE_W(SAMPLE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .dr(dr),
  .rx_sample(rx_sample), .rx_valid(rx_valid)
);

// File: tb/pcm_frame_if_test.sv
module pcm_frame_if_test;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;
  localparam int NS   = 75;
  localparam int W    = 8;

  // {tx byte, rx byte, change tx mid-frame, dt high in idle slots}
  localparam logic [17:0] VEC [8] = '{
    {8'hA5, 8'h3C, 1'b0, 1'b0},
    {8'h00, 8'hFF, 1'b0, 1'b1},
    {8'hFF, 8'h00, 1'b0, 1'b1},
    {8'h80, 8'h01, 1'b1, 1'b0},
    {8'h01, 8'h80, 1'b0, 1'b1},
    {8'h5A, 8'hC3, 1'b1, 1'b1},
    {8'h3C, 8'hA5, 1'b0, 1'b0},
    {8'h96, 8'h69, 1'b1, 1'b0}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] tx_sample = '0;
  logic         dt = 1'b0;
  logic         bclk, fsync, dr, rx_valid;
  logic [W-1:0] rx_sample;

  int    checks = 0;
  int    fails = 0;
  bit    done = 0;
  longint cyc = 0;
  longint last_fs = 0;
  bit    have_fs = 0;
  logic  pb = 1'b0, pfs = 1'b0;
  bit    rose, fell, fsr;

  pcm_frame_if #(.CLK_DIV(DIV), .FRAME_SLOTS(NS), .SAMPLE_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .tx_sample(tx_sample), .dt(dt),
    .bclk(bclk), .fsync(fsync), .dr(dr), .rx_sample(rx_sample), .rx_valid(rx_valid)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    rose = bclk && !pb;
    fell = !bclk && pb;
    fsr  = fsync && !pfs;
    pb   = bclk;
    pfs  = fsync;
  endtask

  task automatic run_frame(input logic [W-1:0] txb, input logic [W-1:0] rxb,
                           input bit mid, input bit idl);
    int slot = 0;
    int guard = 0;
    int hi = 0;
    int vcnt = 0;
    longint lastrise;
    tx_sample = txb;
    dt = idl;
    do begin
      step();
      guard++;
    end while (!fsr && guard < 4 * NS * DIV);
    chk(fsr && rose, "R3 sync starts with bclk rise", {fsr, rose}, 2'b11);
    if (have_fs) chk(cyc - last_fs == NS * DIV, "R2 frame period", cyc - last_fs, NS * DIV);
    last_fs = cyc;
    have_fs = 1;
    lastrise = cyc;
    hi = 1;
    forever begin
      step();
      if (rose) begin
        chk(cyc - lastrise == DIV, "R1 bclk period", cyc - lastrise, DIV);
        lastrise = cyc;
        hi = 0;
        slot++;
        dt = (slot >= 1 && slot <= W) ? rxb[W - slot] : idl;
        if (mid && slot == 2) tx_sample = ~txb;
      end
      if (bclk) hi++;
      if (fell) begin
        chk(hi == HALF, "R1 bclk high time", hi, HALF);
        chk(fsync == (slot == 0), "R3 fsync width", fsync, slot == 0);
        if (slot >= 1 && slot <= W)
          chk(dr == txb[W - slot], mid ? "R4 R8 dr data bit" : "R4 dr data bit", dr, txb[W - slot]);
        else
          chk(dr == 1'b0, "R5 dr idle low", dr, 0);
      end
      if (rx_valid) begin
        vcnt++;
        chk(fell && slot == W, "R7 valid at slot 8 fall", slot, W);
        chk(rx_sample == rxb, "R6 rx byte", rx_sample, rxb);
      end
      if (fell && slot == NS - 1) break;
    end
    chk(vcnt == 1, "R7 one valid per frame", vcnt, 1);
    chk(rx_sample == rxb, "R7 rx_sample held", rx_sample, rxb);
  endtask

  initial begin
    repeat (3) step();
    chk(!bclk && !fsync && !dr && !rx_valid, "R9 reset outputs low",
        {bclk, fsync, dr, rx_valid}, 0);
    chk(rx_sample == '0, "R9 reset rx_sample", rx_sample, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++)
      run_frame(VEC[i][17:10], VEC[i][9:2], VEC[i][1], VEC[i][0]);

    repeat (40) step();
    rst_n = 1'b0;
    dt = 1'b0;
    repeat (3) step();
    chk(!bclk && !fsync && !dr && !rx_valid, "R9 mid-frame reset idle",
        {bclk, fsync, dr, rx_valid}, 0);
    chk(rx_sample == '0, "R9 mid-frame reset rx_sample", rx_sample, 0);
    rst_n = 1'b1;
    begin
      int n = 0;
      do begin
        step();
        n++;
      end while (!rose && n < 4 * DIV);
      chk(n == HALF, "R9 first bclk rise delay", n, HALF);
      chk(fsync == 1'b1, "R9 first rise opens frame", fsync, 1);
    end
    have_fs = 0;
    run_frame(8'hC9, 8'h5E, 1'b0, 1'b1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule